// File: doc/BRIEF.md
# Two-Level Masked Interrupt Request Collector

This block gathers interrupt requests for a small 8-bit controller core. Twelve sources each have a sticky flag and an enable bit. Three of them are core sources: a timer overflow pulse, an edge on an external pin, and a change on a watched port. Their masked terms go straight to the final stage. The other nine are peripheral sources. Their masked terms are ORed together and then gated by one peripheral enable. The final stage ORs the core and peripheral terms and gates the result with a global enable to form the CPU request.

A separate wake output tells the sleep controller that an enabled source is pending. It is taken before the global enable. While the core sleeps, peripheral sources that depend on the stopped system clock are kept out of the wake term. The port pins and the external pin pass through a synchronizer. Each port pin compares its synchronized value with the value it had one cycle earlier, and any enabled pin that differs sets the port-change flag.

Software reaches every register through a small address/data bus. Reads are combinational and writes take effect at the clock edge. A CPU acknowledge clears the global enable and a return strobe sets it again.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset, registers 0 to 6 read as zero, and `irq_o` and `wake_o` are low.
- R2: A one-cycle source pulse sets its flag. The flag stays set until a bus write puts 0 in its bit. Writing 1 to a flag bit leaves the flag unchanged.
- R3: When a set pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R4: A core source contributes to the request when its flag and its enable are both set. Core flags are at address 1: bit 0 is the timer overflow, bit 1 is the external pin edge and bit 2 is the port change. Their enables are control bits 3, 4 and 5 at address 0.
- R5: Peripheral flag `k` is at address 2 bit `k` for k < 8, and at address 3 bit `k-8` otherwise. Its enable is at the same place at address 4 or 5. The peripheral term is the OR of all masked peripheral flags ANDed with control bit 1.
- R6: `irq_o` is control bit 0 (global enable) ANDed with the OR of the core term and the peripheral term.
- R7: Control bit 2 selects the active edge of the external pin: 1 selects rising, 0 selects falling. Only an edge of the selected polarity sets core flag bit 1.
- R8: Bit `p` of address 6 enables change detection on port pin `p`. A change on an enabled pin sets core flag bit 2. A change on a disabled pin has no effect.
- R9: `wake_o` is the OR of the core term and the peripheral term, independent of the global enable. While `sleep_i` is high, peripheral sources marked as clock-dependent are left out of it. By default these are peripheral bits 3 and 6.
- R10: `irq_ack_i` clears the global enable at the next edge and `irq_ret_i` sets it. An acknowledge wins over a return in the same cycle, and both win over a bus write to control bit 0.
- R11: All written fields read back at their own addresses. Address 7 reads the synchronized port pins and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 3 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational |
| tmr0_ovf_i | input | 1 | Timer overflow pulse (core source 0) |
| ext_pin_i | input | 1 | External interrupt pin |
| port_pins_i | input | PORT_W | Watched port pins |
| peri_evt_i | input | N_PERI | Peripheral event pulses |
| irq_ack_i | input | 1 | CPU acknowledge strobe |
| irq_ret_i | input | 1 | Return-from-interrupt strobe |
| sleep_i | input | 1 | Core is asleep |
| irq_o | output | 1 | Interrupt request to the CPU |
| wake_o | output | 1 | Wake request to the sleep controller |

## Verification
The bench builds the block with its default parameters: eight port pins, nine peripheral sources, a two-stage synchronizer and wake filtering enabled. With this configuration the bench can sweep every combination of global enable, peripheral enable, the three core enables and the three core flags. Each combination is crossed with four peripheral flag/enable pairings, and `irq_o` and `wake_o` are predicted from the requirement formulas. Pin-change enables are walked one bit at a time. Both edge polarities, the set/clear collision and the acknowledge/return ordering are each checked directly.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

   localparam int unsigned REG_AW = 3;
   localparam int unsigned REG_DW = 8;

   localparam logic [REG_AW-1:0] A_CTRL    = 3'd0;
   localparam logic [REG_AW-1:0] A_CFLAG   = 3'd1;
   localparam logic [REG_AW-1:0] A_PFLAG_L = 3'd2;
   localparam logic [REG_AW-1:0] A_PFLAG_H = 3'd3;
   localparam logic [REG_AW-1:0] A_PEN_L   = 3'd4;
   localparam logic [REG_AW-1:0] A_PEN_H   = 3'd5;
   localparam logic [REG_AW-1:0] A_PCHG_EN = 3'd6;
   localparam logic [REG_AW-1:0] A_PINS    = 3'd7;

   localparam int unsigned N_CORE    = 3;
   localparam int unsigned CORE_TMR  = 0;
   localparam int unsigned CORE_EXT  = 1;
   localparam int unsigned CORE_PORT = 2;

   // packed from msb: core_en[5:3], rise[2], per_en[1], glb_en[0]
   typedef struct packed {
      logic [N_CORE-1:0] core_en;
      logic              rise;
      logic              per_en;
      logic              glb_en;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
   parameter int unsigned W      = 9,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] cur_o,
   output logic [W-1:0] prev_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_pin_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];
   logic [W-1:0] prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= stage_q[s-1];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= stage_q[STAGES-1];
   end

   assign cur_o  = stage_q[STAGES-1];
   assign prev_o = prev_q;

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned N = 3
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);

   if (N < 1) begin : g_bad_n
      $error("irq_flag_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      f_q <= 1'b0;
         else if (set_i[i]) f_q <= 1'b1;   // set beats a same-cycle clear
         else if (clr_i[i]) f_q <= 1'b0;
      end
      assign q_o[i] = f_q;
   end

endmodule

// File: rtl/irq_mask_tree.sv
module irq_mask_tree #(
   parameter int unsigned          N_CORE      = 3,
   parameter int unsigned          N_PERI      = 9,
   parameter bit                   WAKE_FILTER = 1'b1,
   parameter logic [N_PERI-1:0]    NEEDS_CLK   = '0
) (
   input  logic [N_CORE-1:0] core_flag_i,
   input  logic [N_CORE-1:0] core_en_i,
   input  logic [N_PERI-1:0] peri_flag_i,
   input  logic [N_PERI-1:0] peri_en_i,
   input  logic              per_en_i,
   input  logic              glb_en_i,
   input  logic              sleep_i,
   output logic              irq_o,
   output logic              wake_o
);

   logic              core_term;
   logic [N_PERI-1:0] peri_hit;
   logic              peri_term;
   logic              peri_wake;

   assign core_term = |(core_flag_i & core_en_i);
   assign peri_hit  = peri_flag_i & peri_en_i;
   assign peri_term = per_en_i & (|peri_hit);

   if (WAKE_FILTER) begin : g_filter
      logic [N_PERI-1:0] live_mask;
      assign live_mask = sleep_i ? ~NEEDS_CLK : {N_PERI{1'b1}};
      assign peri_wake = per_en_i & (|(peri_hit & live_mask));
   end else begin : g_plain
      logic unused_sleep;
      assign unused_sleep = sleep_i;
      assign peri_wake    = peri_term;
   end

   assign irq_o  = glb_en_i & (core_term | peri_term);
   assign wake_o = core_term | peri_wake;

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
   import irq_gate_pkg::*;
#(
   parameter int unsigned       PORT_W      = 8,
   parameter int unsigned       N_PERI      = 9,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter bit                WAKE_FILTER = 1'b1,
   parameter logic [N_PERI-1:0] NEEDS_CLK   = 9'h048
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [2:0]        bus_addr_i,
   input  logic              bus_we_i,
   input  logic [7:0]        bus_wdata_i,
   output logic [7:0]        bus_rdata_o,
   input  logic              tmr0_ovf_i,
   input  logic              ext_pin_i,
   input  logic [PORT_W-1:0] port_pins_i,
   input  logic [N_PERI-1:0] peri_evt_i,
   input  logic              irq_ack_i,
   input  logic              irq_ret_i,
   input  logic              sleep_i,
   output logic              irq_o,
   output logic              wake_o
);

   localparam int unsigned SYNC_W = PORT_W + 1;

   if (PORT_W < 1 || PORT_W > REG_DW) begin : g_bad_port
      $error("irq_gate_ctrl: PORT_W must be 1..8");
   end
   if (N_PERI < 1 || N_PERI > 2 * REG_DW) begin : g_bad_peri
      $error("irq_gate_ctrl: N_PERI must be 1..16");
   end

   ctrl_t             ctrl_q;
   logic [N_PERI-1:0] peri_en_q;
   logic [PORT_W-1:0] pchg_en_q;
   logic [N_CORE-1:0] cflag_q;
   logic [N_PERI-1:0] pflag_q;
   logic              glb_en;
   logic [N_CORE-1:0] core_en;

   logic [SYNC_W-1:0] sync_cur, sync_prev;
   logic [PORT_W-1:0] pins_cur, pins_prev;
   logic              ext_cur, ext_prev;
   logic              ext_edge, port_chg;
   logic [N_CORE-1:0] core_set, core_clr;
   logic [N_PERI-1:0] peri_clr;

   function automatic logic wr_hit(input logic [2:0] a);
      return bus_we_i && (bus_addr_i == a);
   endfunction

   // ---------------- input synchronization and detection ----------------
   irq_pin_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({ext_pin_i, port_pins_i}),
      .cur_o  (sync_cur),
      .prev_o (sync_prev)
   );

   assign pins_cur  = sync_cur[PORT_W-1:0];
   assign pins_prev = sync_prev[PORT_W-1:0];
   assign ext_cur   = sync_cur[PORT_W];
   assign ext_prev  = sync_prev[PORT_W];

   assign ext_edge = ctrl_q.rise ? (ext_cur & ~ext_prev) : (~ext_cur & ext_prev);
   assign port_chg = |((pins_cur ^ pins_prev) & pchg_en_q);

   // ---------------- control registers ----------------
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
      end else begin
         if (wr_hit(A_CTRL)) begin
            ctrl_q.core_en <= bus_wdata_i[5:3];
            ctrl_q.rise    <= bus_wdata_i[2];
            ctrl_q.per_en  <= bus_wdata_i[1];
         end
         if (irq_ack_i)            ctrl_q.glb_en <= 1'b0;
         else if (irq_ret_i)       ctrl_q.glb_en <= 1'b1;
         else if (wr_hit(A_CTRL))  ctrl_q.glb_en <= bus_wdata_i[0];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                pchg_en_q <= '0;
      else if (wr_hit(A_PCHG_EN)) pchg_en_q <= bus_wdata_i[PORT_W-1:0];
   end

   for (genvar i = 0; i < N_PERI; i++) begin : g_peri
      localparam logic [2:0] EN_ADDR = (i < REG_DW) ? A_PEN_L   : A_PEN_H;
      localparam logic [2:0] FL_ADDR = (i < REG_DW) ? A_PFLAG_L : A_PFLAG_H;
      localparam int unsigned BITPOS = i % REG_DW;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)              peri_en_q[i] <= 1'b0;
         else if (wr_hit(EN_ADDR)) peri_en_q[i] <= bus_wdata_i[BITPOS];
      end
      assign peri_clr[i] = wr_hit(FL_ADDR) & ~bus_wdata_i[BITPOS];
   end

   // ---------------- flags ----------------
   always_comb begin
      core_set            = '0;
      core_set[CORE_TMR]  = tmr0_ovf_i;
      core_set[CORE_EXT]  = ext_edge;
      core_set[CORE_PORT] = port_chg;
      core_clr = wr_hit(A_CFLAG) ? ~bus_wdata_i[N_CORE-1:0] : '0;
   end

   irq_flag_bank #(.N(N_CORE)) u_core_flags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (core_set),
      .clr_i  (core_clr),
      .q_o    (cflag_q)
   );

   irq_flag_bank #(.N(N_PERI)) u_peri_flags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (peri_evt_i),
      .clr_i  (peri_clr),
      .q_o    (pflag_q)
   );

   // ---------------- masking ----------------
   assign glb_en  = ctrl_q.glb_en;
   assign core_en = ctrl_q.core_en;

   irq_mask_tree #(
      .N_CORE      (N_CORE),
      .N_PERI      (N_PERI),
      .WAKE_FILTER (WAKE_FILTER),
      .NEEDS_CLK   (NEEDS_CLK)
   ) u_tree (
      .core_flag_i (cflag_q),
      .core_en_i   (core_en),
      .peri_flag_i (pflag_q),
      .peri_en_i   (peri_en_q),
      .per_en_i    (ctrl_q.per_en),
      .glb_en_i    (glb_en),
      .sleep_i     (sleep_i),
      .irq_o       (irq_o),
      .wake_o      (wake_o)
   );

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata_o = '0;
      case (bus_addr_i)
         A_CTRL:    bus_rdata_o[CTRL_W-1:0] = ctrl_q;
         A_CFLAG:   bus_rdata_o[N_CORE-1:0] = cflag_q;
         A_PCHG_EN: bus_rdata_o[PORT_W-1:0] = pchg_en_q;
         A_PINS:    bus_rdata_o[PORT_W-1:0] = pins_cur;
         default: begin
            for (int i = 0; i < int'(N_PERI); i++) begin
               if (bus_addr_i == ((i < int'(REG_DW)) ? A_PFLAG_L : A_PFLAG_H))
                  bus_rdata_o[i % REG_DW] = pflag_q[i];
               if (bus_addr_i == ((i < int'(REG_DW)) ? A_PEN_L : A_PEN_H))
                  bus_rdata_o[i % REG_DW] = peri_en_q[i];
            end
         end
      endcase
   end

endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [2:0] bus_addr_i,
   input logic       bus_we_i,
   input logic       wdata_b0,
   input logic       tmr0_ovf_i,
   input logic       irq_ack_i,
   input logic       irq_ret_i,
   input logic       sleep_i,
   input logic       irq_o,
   input logic       wake_o,
   input logic       glb_en,
   input logic [2:0] core_flags,
   input logic [2:0] core_en
);

   logic clr_tmr;
   assign clr_tmr = bus_we_i && (bus_addr_i == 3'd1) && !wdata_b0;

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmr0_ovf_i |=> core_flags[0]);                                   // R3
   AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_flags[0] && !clr_tmr |=> core_flags[0]);                    // R2
   AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_tmr && !tmr0_ovf_i |=> !core_flags[0]);                      // R2
   AST_CORE_REACHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      glb_en && core_en[0] && core_flags[0] |-> irq_o);                // R4
   AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> glb_en);                                               // R6
   AST_WAKE_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o && !sleep_i |-> wake_o);                                   // R9
   AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_ack_i |=> !glb_en);                                          // R10
   AST_RET_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_ret_i && !irq_ack_i |=> glb_en);                             // R10

endmodule

bind irq_gate_ctrl irq_gate_chk u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .bus_addr_i (bus_addr_i),
   .bus_we_i   (bus_we_i),
   .wdata_b0   (bus_wdata_i[0]),
   .tmr0_ovf_i (tmr0_ovf_i),
   .irq_ack_i  (irq_ack_i),
   .irq_ret_i  (irq_ret_i),
   .sleep_i    (sleep_i),
   .irq_o      (irq_o),
   .wake_o     (wake_o),
   .glb_en     (glb_en),
   .core_flags (cflag_q),
   .core_en    (core_en)
);

// File: tb/test_irq_gate_ctrl.sv
module test_irq_gate_ctrl;

   localparam int PW = 8;
   localparam int NP = 9;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [2:0]    addr;
   logic          we;
   logic [7:0]    wdata;
   logic [7:0]    rdata;
   logic          tmr;
   logic          ext;
   logic [PW-1:0] pins;
   logic [NP-1:0] pevt;
   logic          ack, ret, sleep;
   logic          irq, wake;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   irq_gate_ctrl i_irq_gate_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tmr0_ovf_i(tmr),
      .ext_pin_i(ext), .port_pins_i(pins), .peri_evt_i(pevt),
      .irq_ack_i(ack), .irq_ret_i(ret), .sleep_i(sleep),
      .irq_o(irq), .wake_o(wake)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; we = 1'b1; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
   endtask

   task automatic clear_flags();
      wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
   endtask

   task automatic pulse_tmr();
      @(negedge clk); tmr = 1'b1; @(negedge clk); tmr = 1'b0;
   endtask

   task automatic pulse_peri(input logic [NP-1:0] m);
      @(negedge clk); pevt = m; @(negedge clk); pevt = '0;
   endtask

   task automatic toggle_pin(input int p);
      @(negedge clk); pins[p] = ~pins[p]; idle(4);
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      logic [7:0]    d;
      logic [NP-1:0] pf, pen;
      logic          ct, pt;
      rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0; tmr = 1'b0; ext = 1'b0;
      pins = '0; pevt = '0; ack = 1'b0; ret = 1'b0; sleep = 1'b0;
      idle(3); rst_n = 1'b1; idle(2);

      // R1 reset state
      for (int a = 0; a < 7; a++) begin
         rd(3'(a), d); check("R1 reset reg", d, 8'h00);
      end
      check("R1 irq after reset", irq, 0);
      check("R1 wake after reset", wake, 0);

      // R11 readback and pin view
      wr(3'd0, 8'h2A); rd(3'd0, d); check("R11 ctrl readback", d, 8'h2A);
      wr(3'd4, 8'hA5); rd(3'd4, d); check("R11 pen lo readback", d, 8'hA5);
      wr(3'd5, 8'hFF); rd(3'd5, d); check("R11 pen hi readback", d, 8'h01);
      @(negedge clk); pins = 8'h5A; idle(4);
      rd(3'd7, d); check("R11 pins read", d, 8'h5A);
      wr(3'd7, 8'h00); rd(3'd7, d); check("R11 pins write ignored", d, 8'h5A);
      wr(3'd6, 8'h3C); rd(3'd6, d); check("R11 pchg en readback", d, 8'h3C);
      wr(3'd0, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h00); clear_flags();

      // R2 sticky flags
      pulse_tmr(); idle(2); rd(3'd1, d); check("R2 flag set", d[0], 1);
      wr(3'd1, 8'hFF); rd(3'd1, d); check("R2 write one keeps", d[0], 1);
      wr(3'd1, 8'hFE); rd(3'd1, d); check("R2 write zero clears", d[0], 0);
      pulse_peri(9'h100); rd(3'd3, d); check("R2 peri flag 8 set", d, 8'h01);
      wr(3'd3, 8'h00); rd(3'd3, d); check("R2 peri flag 8 cleared", d, 8'h00);

      // R3 set beats clear
      @(negedge clk); addr = 3'd1; we = 1'b1; wdata = 8'h00; tmr = 1'b1;
      @(negedge clk); we = 1'b0; tmr = 1'b0;
      rd(3'd1, d); check("R3 core collision", d[0], 1);
      @(negedge clk); addr = 3'd2; we = 1'b1; wdata = 8'h00; pevt = 9'h001;
      @(negedge clk); we = 1'b0; pevt = '0;
      rd(3'd2, d); check("R3 peri collision", d[0], 1);
      clear_flags();

      // R7 edge select
      wr(3'd0, 8'h00); clear_flags();
      @(negedge clk); ext = 1'b1; idle(5); rd(3'd1, d); check("R7 rising ignored when falling", d[1], 0);
      @(negedge clk); ext = 1'b0; idle(5); rd(3'd1, d); check("R7 falling sets", d[1], 1);
      wr(3'd0, 8'h04); clear_flags();
      @(negedge clk); ext = 1'b1; idle(5); rd(3'd1, d); check("R7 rising sets", d[1], 1);
      clear_flags();
      @(negedge clk); ext = 1'b0; idle(5); rd(3'd1, d); check("R7 falling ignored when rising", d[1], 0);

      // R8 per-pin enable walk
      for (int k = 0; k < PW; k++) begin
         wr(3'd6, 8'(1 << k)); clear_flags();
         toggle_pin((k + 1) % PW); rd(3'd1, d); check("R8 disabled pin ignored", d[2], 0);
         toggle_pin(k);            rd(3'd1, d); check("R8 enabled pin sets", d[2], 1);
      end
      wr(3'd6, 8'h01); clear_flags();

      // R4 R5 R6 R9 sweep (sleep low)
      for (int g = 0; g < 2; g++)
      for (int p = 0; p < 2; p++)
      for (int ce = 0; ce < 8; ce++)
      for (int cf = 0; cf < 8; cf++)
      for (int pi = 0; pi < 4; pi++) begin
         pf  = (pi == 0) ? '0 : ((pi == 1) ? 9'h001 : 9'h100);
         pen = (pi == 0) ? '0 : ((pi == 3) ? 9'h100 : 9'h001);
         clear_flags();
         wr(3'd0, 8'((ce << 3) | 4 | (p << 1) | g));
         wr(3'd4, pen[7:0]); wr(3'd5, {7'b0, pen[8]});
         if (cf[0]) pulse_tmr();
         if (cf[1]) begin
            @(negedge clk); ext = 1'b1; idle(4); ext = 1'b0; idle(4);
         end
         if (cf[2]) toggle_pin(0);
         if (pf != '0) pulse_peri(pf);
         idle(1);
         ct = |(3'(cf) & 3'(ce));
         pt = (p != 0) && ((pf & pen) != '0);
         check("R6 irq sweep", irq, 32'((g != 0) && (ct || pt)));
         check("R9 wake sweep", wake, 32'(ct || pt));
      end

      // R5 peripheral enable alone
      clear_flags(); wr(3'd0, 8'h01); wr(3'd4, 8'h01); wr(3'd5, 8'h00);
      pulse_peri(9'h001); idle(1);
      check("R5 peri blocked by peri enable", irq, 0);
      wr(3'd0, 8'h03); check("R5 peri passes", irq, 1);

      // R9 sleep filtering
      clear_flags(); wr(3'd0, 8'h02); wr(3'd4, 8'h0A);
      pulse_peri(9'h008); idle(1);
      @(negedge clk); sleep = 1'b1; #1;
      check("R9 clock source masked asleep", wake, 0);
      check("R9 no irq without global", irq, 0);
      @(negedge clk); sleep = 1'b0; #1;
      check("R9 clock source awake", wake, 1);
      pulse_peri(9'h002);
      @(negedge clk); sleep = 1'b1; #1;
      check("R9 other source wakes asleep", wake, 1);
      @(negedge clk); sleep = 1'b0;

      // R10 ack / return
      wr(3'd0, 8'h01);
      @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;
      rd(3'd0, d); check("R10 ack clears", d[0], 0);
      @(negedge clk); ret = 1'b1; @(negedge clk); ret = 1'b0;
      rd(3'd0, d); check("R10 ret sets", d[0], 1);
      @(negedge clk); ack = 1'b1; ret = 1'b1; @(negedge clk); ack = 1'b0; ret = 1'b0;
      rd(3'd0, d); check("R10 ack beats ret", d[0], 0);
      @(negedge clk); ack = 1'b1; addr = 3'd0; we = 1'b1; wdata = 8'h01;
      @(negedge clk); ack = 1'b0; we = 1'b0;
      rd(3'd0, d); check("R10 ack beats write", d[0], 0);
      @(negedge clk); ret = 1'b1; addr = 3'd0; we = 1'b1; wdata = 8'h00;
      @(negedge clk); ret = 1'b0; we = 1'b0;
      rd(3'd0, d); check("R10 ret beats write", d[0], 1);

      finish_up();
   end

endmodule